// File: doc/BRIEF.md
# Trap Entry and Privilege Mode Controller

This block sits beside the fetch and execute stages of a 32-bit processor core and turns fault reports and device interrupt lines into a controlled jump into kernel code. Each cycle it looks at the instruction-side fault requests, the privileged-operation strobes and the interrupt lines. It picks at most one event and commits it. Committing means four things: the return address goes into the exception PC register, a numeric reason code goes into the cause register, the core is told to fetch from the single handler address 0x80000180, and the status register drops into kernel mode with interrupts masked.

The status register holds the current privilege bit, an interrupt-enable bit and a saved copy of both. Kernel code can rewrite the status register directly. It can also issue a return strobe, which sends the core back to the saved exception PC and restores the saved mode and enable bits. When user code attempts one of these privileged operations, or any other instruction the pipeline flags as privileged, the operation is not carried out. It becomes a reserved-instruction trap instead.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After synchronous reset, status_o, epc_o and cause_o are all zero and redirect_valid is low. Status bit 0 is the mode bit (0 = kernel, 1 = user), bit 1 is interrupt enable, bit 2 is the saved mode and bit 3 is the saved enable.
- R2: In the cycle after any event is accepted, redirect_valid is high and redirect_pc equals 0x80000180, whatever the reason code.
- R3: Accepting an event copies the mode and enable bits into the saved bits 2 and 3, then clears mode to kernel (0) and clears enable (0).
- R4: epc_o takes next_pc when the event is a syscall or an interrupt. For every other fault it takes inst_pc.
- R5: cause_o[4:0] holds the reason code, with exc_req bit mapping as follows: bit0 fetch address error = 4, bit1 fetch bus error = 6, bit2 reserved opcode = 10, bit3 syscall = 8, bit4 integer overflow = 12, bit5 floating-point error = 15, bit6 load address error = 4, bit7 store address error = 5, bit8 load/store bus error = 7; an interrupt gives 0.
- R6: When several exc_req bits are set together, the lowest-numbered bit wins. Any exc_req bit beats a pending interrupt. Only the winner is recorded.
- R7: An interrupt is accepted only while status bit 1 is set and some irq line is high. While bit 1 is clear, irq has no effect on any output.
- R8: In user mode, priv_op, status_we or ret_strobe raises a reserved-opcode trap (code 10, epc_o = inst_pc). The requested status write or return is not performed.
- R9: In kernel mode with no trap, ret_strobe gives redirect_valid high and redirect_pc equal to epc_o in the next cycle. It also copies saved mode and saved enable back into bits 0 and 1.
- R10: In kernel mode with no trap, status_we loads status bits 3:0 from status_wdata[3:0].
- R11: epc_o and cause_o keep their values in every cycle in which no event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 9 | Instruction fault requests, bit meaning per R5 |
| irq | input | NUM_IRQ | Level-sensitive interrupt lines |
| priv_op | input | 1 | Current instruction is privileged |
| status_we | input | 1 | Privileged write of the status register |
| status_wdata | input | 4 | Data for the status write |
| ret_strobe | input | 1 | Return-from-exception instruction |
| inst_pc | input | XLEN | Address of the current instruction |
| next_pc | input | XLEN | Address of the instruction that would follow |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Fetch restart address |
| epc_o | output | XLEN | Saved exception PC |
| cause_o | output | 32 | Reason code in bits 4:0 |
| status_o | output | 32 | Mode, enable and saved copies in bits 3:0 |

## Verification
The hardest cases to reach are the ones that depend on the state the mode bits are in: a privileged strobe arriving while the core is in user mode, and an interrupt line held high while enable is clear. The stimulus first uses kernel status writes and returns to move the mode and enable bits into the state it wants. Only then does it apply the privileged strobes and interrupts. Priority is exercised by raising several fault bits together with interrupt lines and checking that only the winner's code and return address are recorded.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_EXC   = 9;
    localparam int CODE_W    = 5;
    localparam int STAT_W    = 4;

    localparam logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180;

    localparam int IDX_RESERVED = 2;
    localparam int IDX_SYSCALL  = 3;

    localparam logic [CODE_W-1:0] CODE_INTERRUPT = 5'd0;

    typedef struct packed {
        logic              valid;
        logic              use_next;
        logic [CODE_W-1:0] code;
    } trap_pick_t;

    typedef struct packed {
        logic prev_ie;
        logic prev_user;
        logic ie;
        logic user;
    } status_t;

    function automatic logic [CODE_W-1:0] code_of(input int idx);
        case (idx)
            0:       return 5'd4;
            1:       return 5'd6;
            2:       return 5'd10;
            3:       return 5'd8;
            4:       return 5'd12;
            5:       return 5'd15;
            6:       return 5'd4;
            7:       return 5'd5;
            8:       return 5'd7;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/trap_prio.sv
module trap_prio
    import trap_pkg::*;
#(
    parameter int NUM_IRQ = 6
) (
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic [NUM_IRQ-1:0] irq,
    input  status_t            st,
    input  logic               priv_op,
    input  logic               status_we,
    input  logic               ret_strobe,
    output trap_pick_t         pick
);
    logic [NUM_EXC-1:0] req;
    logic [NUM_EXC-1:0] win;
    logic [CODE_W-1:0]  part [NUM_EXC];

    always_comb begin
        req = exc_req;
        req[IDX_RESERVED] = exc_req[IDX_RESERVED]
                          | (st.user & (priv_op | status_we | ret_strobe));
    end

    assign win[0]  = req[0];
    assign part[0] = req[0] ? code_of(0) : '0;

    for (genvar i = 1; i < NUM_EXC; i++) begin : g_win
        assign win[i]  = req[i] & ~(|req[i-1:0]);
        assign part[i] = win[i] ? code_of(i) : '0;
    end

    always_comb begin
        pick = '0;
        if (|req) begin
            pick.valid    = 1'b1;
            pick.use_next = win[IDX_SYSCALL];
            for (int i = 0; i < NUM_EXC; i++) begin
                pick.code = pick.code | part[i];
            end
        end else if (st.ie && (|irq)) begin
            pick.valid    = 1'b1;
            pick.use_next = 1'b1;
            pick.code     = CODE_INTERRUPT;
        end
    end

endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  logic    ret_do,
    input  logic    wr_do,
    input  status_t wdata,
    output status_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (take) begin
            st.prev_ie   <= st.ie;
            st.prev_user <= st.user;
            st.ie        <= 1'b0;
            st.user      <= 1'b0;
        end else if (ret_do) begin
            st.ie   <= st.prev_ie;
            st.user <= st.prev_user;
        end else if (wr_do) begin
            st <= wdata;
        end
    end

    AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
        take |=> (!st.user && !st.ie && st.prev_user == $past(st.user)
                  && st.prev_ie == $past(st.ie))); // R3

    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (rst)
        ret_do |=> (st.user == $past(st.prev_user) && st.ie == $past(st.prev_ie))); // R9

endmodule

// File: rtl/trap_capture.sv
module trap_capture
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              use_next,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   inst_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic              ret_do,
    output logic [XLEN-1:0]   epc,
    output logic [CODE_W-1:0] cause_code,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc            <= '0;
            cause_code     <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= take | ret_do;
            if (take) begin
                epc         <= use_next ? next_pc : inst_pc;
                cause_code  <= code;
                redirect_pc <= HANDLER_VEC;
            end else if (ret_do) begin
                redirect_pc <= epc;
            end
        end
    end

    AST_VECTOR_FIXED: assert property (@(posedge clk) disable iff (rst)
        take |=> (redirect_valid && redirect_pc == HANDLER_VEC)); // R2

    AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(epc) && $stable(cause_code))); // R11

    AST_EPC_FAULT: assert property (@(posedge clk) disable iff (rst)
        (take && !use_next) |=> (epc == $past(inst_pc))); // R4

    AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
        (ret_do && !take) |=> (redirect_valid && redirect_pc == $past(epc))); // R9

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int NUM_IRQ = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic               priv_op,
    input  logic               status_we,
    input  logic [STAT_W-1:0]  status_wdata,
    input  logic               ret_strobe,
    input  logic [XLEN-1:0]    inst_pc,
    input  logic [XLEN-1:0]    next_pc,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    epc_o,
    output logic [31:0]        cause_o,
    output logic [31:0]        status_o
);
    status_t           st;
    trap_pick_t        pick;
    logic              ret_do;
    logic              wr_do;
    logic [CODE_W-1:0] cause_code;

    assign ret_do = ret_strobe & ~st.user & ~pick.valid;
    assign wr_do  = status_we  & ~st.user & ~pick.valid;

    trap_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .exc_req    (exc_req),
        .irq        (irq),
        .st         (st),
        .priv_op    (priv_op),
        .status_we  (status_we),
        .ret_strobe (ret_strobe),
        .pick       (pick)
    );

    trap_status u_status (
        .clk    (clk),
        .rst    (rst),
        .take   (pick.valid),
        .ret_do (ret_do),
        .wr_do  (wr_do),
        .wdata  (status_t'(status_wdata)),
        .st     (st)
    );

    trap_capture u_capture (
        .clk            (clk),
        .rst            (rst),
        .take           (pick.valid),
        .use_next       (pick.use_next),
        .code           (pick.code),
        .inst_pc        (inst_pc),
        .next_pc        (next_pc),
        .ret_do         (ret_do),
        .epc            (epc_o),
        .cause_code     (cause_code),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    assign status_o = {{(32-STAT_W){1'b0}}, st};
    assign cause_o  = {{(32-CODE_W){1'b0}}, cause_code};

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (!status_o[1] && exc_req == '0 && !ret_strobe
         && !(status_o[0] && (priv_op || status_we)))
        |=> !redirect_valid); // R7

    AST_USER_PRIV_TRAP: assert property (@(posedge clk) disable iff (rst)
        (status_o[0] && exc_req[1:0] == 2'b00 && (priv_op || status_we || ret_strobe))
        |=> (cause_o[4:0] == 5'd10 && redirect_pc == HANDLER_VEC)); // R8

endmodule

// File: tb/tb_trap_entry_ctrl.sv
module tb_trap_entry_ctrl;
    import trap_pkg::*;

    localparam int NIRQ = 6;

    typedef struct {
        int          due;
        string       tag;
        logic        rv;
        logic [31:0] rpc;
        logic [31:0] epc;
        logic [31:0] cause;
        logic [31:0] stat;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_EXC-1:0] exc_req = '0;
    logic [NIRQ-1:0]   irq = '0;
    logic              priv_op = 1'b0, status_we = 1'b0, ret_strobe = 1'b0;
    logic [3:0]        status_wdata = '0;
    logic [31:0]       inst_pc = '0, next_pc = '0;
    logic              redirect_valid;
    logic [31:0]       redirect_pc, epc_o, cause_o, status_o;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t q[$];

    logic [3:0]  m_st = '0;
    logic [31:0] m_epc = '0;
    logic [4:0]  m_cause = '0;
    int          codes [NUM_EXC] = '{4, 6, 10, 8, 12, 15, 4, 5, 7};

    trap_entry_ctrl #(.NUM_IRQ(NIRQ)) dut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .irq(irq), .priv_op(priv_op),
        .status_we(status_we), .status_wdata(status_wdata), .ret_strobe(ret_strobe),
        .inst_pc(inst_pc), .next_pc(next_pc), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .epc_o(epc_o), .cause_o(cause_o), .status_o(status_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares results against queued expectations
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (redirect_valid !== e.rv || (e.rv && redirect_pc !== e.rpc) ||
                epc_o !== e.epc || cause_o !== e.cause || status_o !== e.stat) begin
                bad++;
                $display("FAIL %s: got rv=%0b pc=%h epc=%h cause=%0d st=%h exp rv=%0b pc=%h epc=%h cause=%0d st=%h",
                         e.tag, redirect_valid, redirect_pc, epc_o, cause_o, status_o,
                         e.rv, e.rpc, e.epc, e.cause, e.stat);
            end
        end
    end

    // driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic op(input string tag, input logic [NUM_EXC-1:0] ex, input logic [NIRQ-1:0] ir,
                      input logic pv, input logic swe, input logic [3:0] wd, input logic rt,
                      input logic [31:0] ipc, input logic [31:0] npc);
        exp_t        e;
        logic [NUM_EXC-1:0] req;
        logic        take;
        logic        nxt;
        logic [4:0]  code;
        int          win;
        @(posedge clk);
        #2;
        exc_req = ex; irq = ir; priv_op = pv; status_we = swe; status_wdata = wd;
        ret_strobe = rt; inst_pc = ipc; next_pc = npc;
        req = ex;
        if (m_st[0] && (pv || swe || rt)) req[2] = 1'b1;
        take = 1'b0; nxt = 1'b0; code = '0; win = -1;
        for (int i = NUM_EXC - 1; i >= 0; i--) if (req[i]) win = i;
        if (win >= 0) begin
            take = 1'b1; code = 5'(codes[win]); nxt = (win == 3);
        end else if (m_st[1] && (|ir)) begin
            take = 1'b1; code = 5'd0; nxt = 1'b1;
        end
        e.rv = 1'b0; e.rpc = '0;
        if (take) begin
            m_epc = nxt ? npc : ipc;
            m_cause = code;
            m_st = {m_st[1], m_st[0], 2'b00};
            e.rv = 1'b1; e.rpc = 32'h8000_0180;
        end else if (rt) begin
            e.rv = 1'b1; e.rpc = m_epc;
            m_st = {m_st[3], m_st[2], m_st[3], m_st[2]};
        end else if (swe) begin
            m_st = wd;
        end
        e.due = cyc + 1; e.tag = tag;
        e.epc = m_epc; e.cause = {27'b0, m_cause}; e.stat = {28'b0, m_st};
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        op(tag, '0, '0, 0, 0, 4'h0, 0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        idle("R1 reset state");
        op("R10 kernel status write", '0, '0, 0, 1, 4'b0011, 0, 32'h100, 32'h104);
        op("R7 R2 R3 R4 interrupt taken", '0, 6'b000100, 0, 0, 4'h0, 0, 32'h200, 32'h204);
        idle("R11 hold after entry");
        op("R9 return restores", '0, '0, 0, 0, 4'h0, 1, 32'h300, 32'h304);
        op("R8 user priv_op", '0, '0, 1, 0, 4'h0, 0, 32'h400, 32'h404);
        op("R9 return again", '0, '0, 0, 0, 4'h0, 1, 32'h500, 32'h504);
        op("R8 user status write blocked", '0, '0, 0, 1, 4'b0000, 0, 32'h600, 32'h604);
        op("R10 kernel clears enable", '0, '0, 0, 1, 4'b0000, 0, 32'h700, 32'h704);
        op("R7 masked irq ignored", '0, 6'b111111, 0, 0, 4'h0, 0, 32'h800, 32'h804);
        op("R4 syscall next pc", 9'b000001000, 6'b000001, 0, 0, 4'h0, 0, 32'h900, 32'h904);
        op("R6 overflow beats load addr", 9'b001010000, '0, 0, 0, 4'h0, 0, 32'hA00, 32'hA04);
        op("R6 store addr beats bus err", 9'b110000000, '0, 0, 0, 4'h0, 0, 32'hB00, 32'hB04);
        for (int i = 0; i < NUM_EXC; i++) begin
            op($sformatf("R5 code for bit %0d", i), 9'(1 << i), '0, 0, 0, 4'h0, 0,
               32'h1000 + 32'(i * 16), 32'h1004 + 32'(i * 16));
        end
        op("R10 enable interrupts", '0, '0, 0, 1, 4'b0010, 0, 32'hC00, 32'hC04);
        op("R6 fp error beats interrupt", 9'b000100000, 6'b100000, 0, 0, 4'h0, 0, 32'hD00, 32'hD04);
        op("R10 re-enable", '0, '0, 0, 1, 4'b0010, 0, 32'hE00, 32'hE04);
        op("R7 R4 interrupt next pc", '0, 6'b010000, 0, 0, 4'h0, 0, 32'hF00, 32'hF04);
        op("R11 hold with masked irq", '0, 6'b010000, 0, 0, 4'h0, 0, 32'hF10, 32'hF14);
        idle("R11 idle end");
        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule